// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a register-mapped watchdog for a system controller. A 10-bit counter starts at a programmable initial value. It counts down by one on each cycle where the coarse tick enable is high and the control register's halt bit is clear. One tick is nominally 0.6 s, and the tick source is outside the block. Software keeps the system alive by writing the reload code to the counter register. That write puts the programmed initial value back into the counter.

If software misses the deadline, the first expiry only raises a timeout flag and its interrupt, and the counter reloads and keeps running. A second expiry that arrives while the timeout flag is still set records a second-timeout flag and sends a one-cycle reset request to the system. A no-reboot mask input can hold that reset request back; the status flags still update as normal. The bus is a simple synchronous 16-bit port with byte-lane enables. Every read returns its data one cycle after the address is presented.

Top module: `wdt_two_stage`

## Requirements
- R1: After synchronous reset, the counter and the low 10 bits of the initial-value register hold INIT_RST, and the upper 6 bits of that register are 0. The halt bit is 1, the event bit and both status flags are 0, and rst_req, to_irq and bus_rdata are 0.
- R2: The counter decrements by exactly one on every clock where tick_en is 1 and halt (control bit 11) is 0. It holds its value when tick_en is 0 or halt is 1.
- R3: A write to offset 0x00 with lane 0 enabled and wdata[7:0] equal to 0x01 loads the counter from the initial-value field. Any other value written there has no effect. A reload takes priority over a tick in the same cycle.
- R4: The initial-value register sits at offset 0x12. Bits [9:0] are the count start and bits [15:10] are plain storage, and each byte lane is written only when its enable is set. If the merged low field would be 0 to 3, the previous low field is kept, while bits [15:10] still take the write.
- R5: A read of offset 0x00 returns the live counter in bits [9:0] and zero above. The data appears on bus_rdata one clock after the address; unmapped offsets read 0.
- R6: A tick while the counter is 0 is an expiry. The counter reloads from the initial-value field, bit 3 of the status register at 0x04 is set, and to_irq follows that bit.
- R7: Writing 1 to bit 3 at 0x04 clears it, and writing 1 to bit 1 at 0x06 clears that bit. Writing 0 leaves a flag unchanged. If an expiry sets a flag in the same cycle as a clear, the flag is set.
- R8: An expiry while bit 3 at 0x04 is already set sets bit 1 at 0x06 and drives rst_req high for exactly one cycle, in the cycle after the expiry tick.
- R9: While no_reboot is high, a second expiry sets bit 1 at 0x06 and changes no other status, but rst_req stays low.
- R10: Writing 1 to control bit 8 (offset 0x08, lane 1) inverts the stored event bit, and writing 0 leaves it unchanged. The event bit has no effect on counting.
- R11: Control bit 11 (the halt bit) takes the written value on every lane-1 write to 0x08. All control bits other than 8 and 11 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_be | input | 2 | Byte-lane write enables |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered, one cycle after the address |
| tick_en | input | 1 | Coarse timer tick, one cycle wide per tick |
| no_reboot | input | 1 | Masks the reset request when high |
| rst_req | output | 1 | One-cycle system reset request |
| to_irq | output | 1 | First-timeout interrupt, level |

## Verification
The bench targets the cycle where the counter sits at zero. If a design expired one tick early or late, or reloaded from the wrong value, every timeout would move by one and the reference model would catch it. The two-strike rule is driven both with and without a clear between expiries. A design that reset on the first expiry, or kept counting strikes after a clear, would show an extra or a missing rst_req pulse. Other targets are an expiry landing on the same cycle as a clear, the rejected initial values 0 to 3 next to an accepted upper byte, a reload code other than 0x01, and the toggling event bit. Each of these shows up as a wrong flag, a wrong read-back, or a counter that moves when it should not.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DW        = 16;
  localparam int LANES     = DW / 8;
  localparam int OFS_COUNT = 'h00;
  localparam int OFS_STS1  = 'h04;
  localparam int OFS_STS2  = 'h06;
  localparam int OFS_CTRL  = 'h08;
  localparam int OFS_INIT  = 'h12;
  localparam int BIT_TO    = 3;
  localparam int BIT_SEC   = 1;
  localparam int BIT_EVT   = 8;
  localparam int BIT_HALT  = 11;
  localparam int MIN_INIT  = 4;
  localparam logic [7:0] RELOAD_CODE = 8'h01;

  typedef struct packed {
    logic halt;
    logic evt;
  } ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int CNT_W    = 10,
  parameter int INIT_RST = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LANES-1:0]  bus_be,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              sts1,
  input  logic              sts2,
  output logic [CNT_W-1:0]  init_val,
  output logic              halt,
  output logic              reload_req,
  output logic              clr_to,
  output logic              clr_sec
);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_STS1 = ADDR_W'(OFS_STS1);
  localparam logic [ADDR_W-1:0] A_STS2 = ADDR_W'(OFS_STS2);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_INIT = ADDR_W'(OFS_INIT);
  localparam logic [DW-1:0]     INIT_Q_RST = DW'(INIT_RST);

  logic [DW-1:0] init_q;
  logic [DW-1:0] init_merged;
  logic [DW-1:0] init_next;
  ctrl_t         ctrl_q;
  logic          wr_cnt, wr_sts1, wr_sts2, wr_ctrl, wr_init;

  assign wr_cnt  = bus_wr && (bus_addr == A_CNT);
  assign wr_sts1 = bus_wr && (bus_addr == A_STS1);
  assign wr_sts2 = bus_wr && (bus_addr == A_STS2);
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL) && bus_be[1];
  assign wr_init = bus_wr && (bus_addr == A_INIT);

  assign reload_req = wr_cnt && bus_be[0] && (bus_wdata[7:0] == RELOAD_CODE);
  assign clr_to     = wr_sts1 && bus_be[0] && bus_wdata[BIT_TO];
  assign clr_sec    = wr_sts2 && bus_be[0] && bus_wdata[BIT_SEC];

  // byte-lane merge of the initial-value register
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign init_merged[g*8 +: 8] = bus_be[g] ? bus_wdata[g*8 +: 8] : init_q[g*8 +: 8];
  end

  always_comb begin
    init_next = init_merged;
    if (init_merged[CNT_W-1:0] < CNT_W'(MIN_INIT))
      init_next[CNT_W-1:0] = init_q[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q      <= INIT_Q_RST;
      ctrl_q.halt <= 1'b1;
      ctrl_q.evt  <= 1'b0;
    end else begin
      if (wr_init) init_q <= init_next;
      if (wr_ctrl) begin
        ctrl_q.halt <= bus_wdata[BIT_HALT];
        if (bus_wdata[BIT_EVT]) ctrl_q.evt <= ~ctrl_q.evt;
      end
    end
  end

  assign init_val = init_q[CNT_W-1:0];
  assign halt     = ctrl_q.halt;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      unique case (bus_addr)
        A_CNT:   bus_rdata <= DW'(cnt);
        A_STS1:  bus_rdata[BIT_TO]  <= sts1;
        A_STS2:  bus_rdata[BIT_SEC] <= sts2;
        A_CTRL: begin
          bus_rdata[BIT_HALT] <= ctrl_q.halt;
          bus_rdata[BIT_EVT]  <= ctrl_q.evt;
        end
        A_INIT:  bus_rdata <= init_q;
        default: bus_rdata <= '0;
      endcase
    end
  end

  AST_INIT_FLOOR: assert property (@(posedge clk) disable iff (rst)
    init_q[CNT_W-1:0] >= CNT_W'(MIN_INIT)); // R4
  AST_SMALL_INIT_KEPT: assert property (@(posedge clk) disable iff (rst)
    (wr_init && init_merged[CNT_W-1:0] < CNT_W'(MIN_INIT))
      |=> $stable(init_q[CNT_W-1:0])); // R4
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W    = 10,
  parameter int INIT_RST = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick_en,
  input  logic             reload_req,
  input  logic [CNT_W-1:0] init_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic step;
  logic at_zero;

  assign step    = run && tick_en;
  assign at_zero = (cnt == '0);
  assign expire  = step && at_zero && !reload_req;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= CNT_W'(INIT_RST);
    else if (reload_req) cnt <= init_val;
    else if (step)       cnt <= at_zero ? init_val : cnt - 1'b1;
  end

  AST_DEC_ONE: assert property (@(posedge clk) disable iff (rst)
    (step && !reload_req && !at_zero) |=> (cnt == $past(cnt) - 1'b1)); // R2
  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!step && !reload_req) |=> $stable(cnt)); // R2
  AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (rst)
    reload_req |=> (cnt == $past(init_val))); // R3
  AST_EXPIRE_RELOAD: assert property (@(posedge clk) disable iff (rst)
    expire |=> (cnt == $past(init_val))); // R6
endmodule

// File: rtl/wdt_status.sv
module wdt_status (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic clr_to,
  input  logic clr_sec,
  input  logic no_reboot,
  output logic sts1,
  output logic sts2,
  output logic rst_req
);
  logic strike2;

  assign strike2 = expire && sts1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts1    <= 1'b0;
      sts2    <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (expire)      sts1 <= 1'b1;
      else if (clr_to) sts1 <= 1'b0;
      if (strike2)      sts2 <= 1'b1;
      else if (clr_sec) sts2 <= 1'b0;
      rst_req <= strike2 && !no_reboot;
    end
  end

  AST_FIRST_FLAG: assert property (@(posedge clk) disable iff (rst)
    expire |=> sts1); // R6
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req); // R8
  AST_RST_WITH_SEC: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> sts2); // R8
  AST_MASKED: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> !$past(no_reboot)); // R9
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (clr_to && !expire) |=> !sts1); // R7
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int CNT_W    = 10,
  parameter int INIT_RST = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_be,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              tick_en,
  input  logic              no_reboot,
  output logic              rst_req,
  output logic              to_irq
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] init_val;
  logic halt, reload_req, clr_to, clr_sec, expire, sts1, sts2;

  wdt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .INIT_RST(INIT_RST)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt(cnt), .sts1(sts1),
    .sts2(sts2), .init_val(init_val), .halt(halt), .reload_req(reload_req),
    .clr_to(clr_to), .clr_sec(clr_sec)
  );

  wdt_counter #(.CNT_W(CNT_W), .INIT_RST(INIT_RST)) u_cnt (
    .clk(clk), .rst(rst), .run(!halt), .tick_en(tick_en),
    .reload_req(reload_req), .init_val(init_val), .cnt(cnt), .expire(expire)
  );

  wdt_status u_sts (
    .clk(clk), .rst(rst), .expire(expire), .clr_to(clr_to), .clr_sec(clr_sec),
    .no_reboot(no_reboot), .sts1(sts1), .sts2(sts2), .rst_req(rst_req)
  );

  assign to_irq = sts1;

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (halt && !reload_req) |=> $stable(cnt)); // R11
endmodule

// File: tb/tb_wdt_two_stage.sv
module tb_wdt_two_stage;
  localparam int INIT_RST = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        tick_en = 1'b0;
  logic        no_reboot = 1'b0;
  logic        rst_req, to_irq;

  int total = 0;
  int bad = 0;
  int pulses = 0;

  always #2 clk = ~clk;

  wdt_two_stage #(.ADDR_W(5), .CNT_W(10), .INIT_RST(INIT_RST)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
    .no_reboot(no_reboot), .rst_req(rst_req), .to_irq(to_irq)
  );

  // behavioural reference model
  logic [9:0]  m_cnt;
  logic [15:0] m_init, m_rdata;
  logic        m_halt, m_evt, m_s1, m_s2, m_rst;
  string       m_tag = "R1";

  always @(posedge clk) begin
    logic [15:0] rd, nin;
    logic rl, run, ex;
    if (rst) begin
      m_cnt = 10'(INIT_RST); m_init = 16'(INIT_RST); m_halt = 1'b1; m_evt = 1'b0;
      m_s1 = 1'b0; m_s2 = 1'b0; m_rst = 1'b0; m_rdata = '0; m_tag = "R1";
    end else begin
      case (bus_addr)
        5'h00: begin rd = {6'd0, m_cnt}; m_tag = "R5"; end
        5'h04: begin rd = m_s1 ? 16'h0008 : 16'h0000; m_tag = "R7"; end
        5'h06: begin rd = m_s2 ? 16'h0002 : 16'h0000; m_tag = "R8"; end
        5'h08: begin rd = {4'd0, m_halt, 2'd0, m_evt, 8'd0}; m_tag = "R11"; end
        5'h12: begin rd = m_init; m_tag = "R4"; end
        default: begin rd = '0; m_tag = "R5"; end
      endcase
      rl  = bus_wr && bus_addr == 5'h00 && bus_be[0] && bus_wdata[7:0] == 8'h01;
      run = !m_halt && tick_en;
      ex  = run && !rl && m_cnt == 10'd0;
      m_rst = ex && m_s1 && !no_reboot;
      if (ex && m_s1) m_s2 = 1'b1;
      else if (bus_wr && bus_addr == 5'h06 && bus_be[0] && bus_wdata[1]) m_s2 = 1'b0;
      if (ex) m_s1 = 1'b1;
      else if (bus_wr && bus_addr == 5'h04 && bus_be[0] && bus_wdata[3]) m_s1 = 1'b0;
      if (rl) m_cnt = m_init[9:0];
      else if (run) m_cnt = (m_cnt == 10'd0) ? m_init[9:0] : m_cnt - 10'd1;
      if (bus_wr && bus_addr == 5'h08 && bus_be[1]) begin
        m_halt = bus_wdata[11];
        if (bus_wdata[8]) m_evt = !m_evt;
      end
      if (bus_wr && bus_addr == 5'h12) begin
        nin = m_init;
        if (bus_be[0]) nin[7:0]  = bus_wdata[7:0];
        if (bus_be[1]) nin[15:8] = bus_wdata[15:8];
        if (nin[9:0] < 10'd4) nin[9:0] = m_init[9:0];
        m_init = nin;
      end
      m_rdata = rd;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    chk(m_tag, bus_rdata, m_rdata);
    chk("R8", {15'd0, rst_req}, {15'd0, m_rst});
    chk("R6", {15'd0, to_irq}, {15'd0, m_s1});
    if (rst_req === 1'b1) pulses++;
  end

  task automatic wr_reg(input logic [4:0] a, input logic [1:0] be, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd_reg(input logic [4:0] a, input logic [15:0] exp, input string tag);
    bus_addr = a;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd_reg(5'h08, 16'h0800, "R1");
    rd_reg(5'h00, 16'(INIT_RST), "R1");
    rd_reg(5'h04, 16'h0000, "R1");
    rd_reg(5'h12, 16'(INIT_RST), "R1");
    chk("R1", {15'd0, rst_req}, 16'd0);
    // R2 halted after reset: ticks do nothing
    ticks(4);
    rd_reg(5'h00, 16'd8, "R2");
    wr_reg(5'h08, 2'b10, 16'h0000);
    ticks(3);
    rd_reg(5'h00, 16'd5, "R2");
    // R4 initial-value register
    wr_reg(5'h12, 2'b11, 16'hFC06);
    rd_reg(5'h12, 16'hFC06, "R4");
    wr_reg(5'h12, 2'b11, 16'h0002);
    rd_reg(5'h12, 16'h0006, "R4");
    // R3 reload code
    wr_reg(5'h00, 2'b01, 16'h0002);
    rd_reg(5'h00, 16'd5, "R3");
    wr_reg(5'h00, 2'b01, 16'h0001);
    rd_reg(5'h00, 16'd6, "R3");
    // R6 first expiry
    ticks(7);
    rd_reg(5'h04, 16'h0008, "R6");
    chk("R6", {15'd0, to_irq}, 16'd1);
    rd_reg(5'h00, 16'd6, "R6");
    // R8 second expiry
    p0 = pulses;
    ticks(7);
    rd_reg(5'h06, 16'h0002, "R8");
    chk("R8", 16'(pulses - p0), 16'd1);
    // R7 write-one-to-clear
    wr_reg(5'h04, 2'b01, 16'h0000);
    rd_reg(5'h04, 16'h0008, "R7");
    wr_reg(5'h04, 2'b01, 16'h0008);
    rd_reg(5'h04, 16'h0000, "R7");
    wr_reg(5'h06, 2'b01, 16'h0002);
    rd_reg(5'h06, 16'h0000, "R7");
    // R9 masked reset
    no_reboot = 1'b1;
    p0 = pulses;
    ticks(14);
    rd_reg(5'h06, 16'h0002, "R9");
    rd_reg(5'h04, 16'h0008, "R9");
    chk("R9", 16'(pulses - p0), 16'd0);
    no_reboot = 1'b0;
    wr_reg(5'h04, 2'b01, 16'h0008);
    wr_reg(5'h06, 2'b01, 16'h0002);
    // R10 event toggle
    wr_reg(5'h08, 2'b10, 16'h0100);
    rd_reg(5'h08, 16'h0100, "R10");
    rd_reg(5'h00, 16'd6, "R10");
    wr_reg(5'h08, 2'b10, 16'h0000);
    rd_reg(5'h08, 16'h0100, "R10");
    wr_reg(5'h08, 2'b10, 16'h0100);
    rd_reg(5'h08, 16'h0000, "R10");
    // R11 other bits read zero, halt freezes
    wr_reg(5'h08, 2'b10, 16'hF6FF);
    rd_reg(5'h08, 16'h0000, "R11");
    wr_reg(5'h08, 2'b10, 16'h0800);
    ticks(5);
    rd_reg(5'h00, 16'd6, "R11");
    // R7 set wins over a same-cycle clear
    wr_reg(5'h08, 2'b10, 16'h0000);
    ticks(7);
    ticks(6);
    tick_en = 1'b1;
    wr_reg(5'h04, 2'b01, 16'h0008);
    tick_en = 1'b0;
    rd_reg(5'h04, 16'h0008, "R7");
    rd_reg(5'h06, 16'h0002, "R8");
    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] alist [6];
      alist = '{5'h00, 5'h04, 5'h06, 5'h08, 5'h12, 5'h02};
      bus_addr  = alist[$urandom % 6];
      bus_wr    = ($urandom % 4) == 0;
      bus_be    = 2'($urandom);
      bus_wdata = 16'($urandom);
      if (bus_addr == 5'h12) bus_wdata[9:0] = 10'($urandom % 12);
      if (bus_addr == 5'h00 && ($urandom % 2) == 0) bus_wdata[7:0] = 8'h01;
      if (bus_addr == 5'h08 && ($urandom % 4) != 0) bus_wdata[11] = 1'b0;
      tick_en   = ($urandom % 2) == 0;
      no_reboot = ($urandom % 8) == 0;
      @(negedge clk);
    end
    bus_wr = 1'b0; tick_en = 1'b0; no_reboot = 1'b0;
    // R1 reset from a running state
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd_reg(5'h08, 16'h0800, "R1");
    rd_reg(5'h06, 16'h0000, "R1");
    rd_reg(5'h12, 16'(INIT_RST), "R1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule